// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the slave-side command front end of a byte-addressed serial memory holding 131,072 bytes. It oversamples the serial clock, data input, select and pause inputs with a faster system clock. It decodes the 8-bit command byte and gathers a three-byte address. A read streams array data back serially. A write passes the incoming bytes, each with its own address, to a separate page-program unit.

The block works with SPI mode 0 and mode 3 hosts. Input bits are taken on rising serial clock edges and output bits change on falling edges. All fields travel most significant bit first. The serial output is presented as a data bit plus an output enable, so the pad cell outside can form the three-state driver. Array storage, protection decisions and program timing are outside the block. The block sees them only through a one-clock-latency read port, a busy input and a status byte input.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: Input bits are captured on rising serial clock edges and output bits change on falling edges, MSB first. Mode 0 (clock idles low) and mode 3 (clock idles high) both work. The falling edge that precedes the first rising edge in mode 3 has no effect.
- R2: The command byte is compared with bit 3 ignored and bits 7..4 required to be zero. The low three bits select: 110 set-write-enable (one-clock pulse on `op_wren_o`), 100 clear-write-enable (pulse on `op_wrdi_o`), 101 status read, 001 status write, 011 array read, 010 array write.
- R3: An unrecognised command byte makes the block ignore all further serial input and keep `so_oe_o` low until select is deasserted and asserted again.
- R4: The address phase is three bytes long. Bits 23..17 are discarded and bits 16..0 select the byte.
- R5: An array read returns the addressed byte and then keeps streaming. The address increments by one per byte and wraps from 0x1FFFF to 0x00000. Serial input after the address is ignored.
- R6: While `cs_n_i` is high, serial input is ignored, `so_oe_o` is low and no command pulse is produced. This is also the state after reset.
- R7: `hold_n_i` low, taken while the serial clock is low, pauses the transfer. While paused, `so_oe_o` is low, clock edges and input data are ignored, and `so_o` is frozen. Raising `hold_n_i` while the clock is low resumes at the same bit.
- R8: While `busy_i` is high when the command byte completes, only the status read command is accepted. Every other command is ignored for the rest of that selection.
- R9: An array write emits one `wr_byte_vld_o` pulse per received data byte, with `wr_addr_o` and `wr_byte_o`. The address advances in its low 7 bits only, wrapping inside the 128-byte page. `wr_commit_o` pulses once when select is released after at least one data byte.
- R10: A status read streams `status_i` repeatedly, one full byte per eight clocks. A status write forwards its single data byte on `wr_byte_o` with a `sr_wr_vld_o` pulse.
- R11: `mem_rd_req_o` is issued with the start address once the last address bit is captured, before the first data bit is driven. One further request follows per byte sent. Data on `mem_rd_data_i` is expected one clock after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| cs_n_i | input | 1 | Active-low select (asynchronous) |
| si_i | input | 1 | Serial data from the host (asynchronous) |
| hold_n_i | input | 1 | Active-low pause (asynchronous) |
| busy_i | input | 1 | Internal program cycle in progress |
| status_i | input | 8 | Status byte returned by a status read |
| mem_rd_data_i | input | 8 | Array read data, valid one clock after a request |
| so_o | output | 1 | Serial output data bit |
| so_oe_o | output | 1 | Output enable for the serial output driver |
| mem_rd_req_o | output | 1 | Array read request pulse |
| mem_rd_addr_o | output | 17 | Array read address |
| op_wren_o | output | 1 | Set-write-enable command pulse |
| op_wrdi_o | output | 1 | Clear-write-enable command pulse |
| sr_wr_vld_o | output | 1 | Status write byte valid pulse |
| wr_byte_vld_o | output | 1 | Array write byte valid pulse |
| wr_addr_o | output | 17 | Array address of the forwarded write byte |
| wr_byte_o | output | 8 | Forwarded write or status byte |
| wr_commit_o | output | 1 | Pulse at deselect after an array write with data |

## Verification
Reads run with random start addresses in both clock modes, with random junk in the discarded address bits. This separates correct address capture, MSB-first shifting and per-byte increment. A read starting just below the top of the array shows full-array wrap, and a write starting near the end of a page shows page-local wrap. Decoding with bit 3 set and with illegal upper bits distinguishes don't-care bits from required ones. Pause during a read, clocking while deselected, and commands issued while busy each check that ignored stimulus leaves the output enable, pulses and resumed data unchanged.

// File: rtl/spi_mem_pkg.sv
// Shared types for the serial memory command interface: sequence phases,
// command kinds and the command byte decoder.
package spi_mem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,  // selected, waiting for the command byte
        PH_ADDR,  // collecting address bytes
        PH_RD,    // streaming array data
        PH_WR,    // forwarding array write bytes
        PH_STAT,  // streaming the status byte
        PH_SRIN,  // taking the status write byte
        PH_MUTE   // ignoring everything until deselect
    } phase_t;

    typedef enum logic [2:0] {
        OPK_WREN, OPK_WRDI, OPK_RDSR, OPK_WRSR, OPK_READ, OPK_WRITE, OPK_BAD
    } opkind_t;

    // Classify a command byte; bit 3 is a don't-care, bits 7..4 must be zero.
    function automatic opkind_t decode_op(input logic [7:0] b);
        opkind_t k;
        if (b[7:4] != 4'h0) begin
            k = OPK_BAD;
        end else begin
            case (b[2:0])
                3'b110:  k = OPK_WREN;
                3'b100:  k = OPK_WRDI;
                3'b101:  k = OPK_RDSR;
                3'b001:  k = OPK_WRSR;
                3'b011:  k = OPK_READ;
                3'b010:  k = OPK_WRITE;
                default: k = OPK_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
// Two-flop synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module spi_mem_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi_mem_clkev.sv
// Serial clock edge detector with pause gating.
// Produces one-cycle rise/fall events in the system clock domain, only while
// selected and not paused. The pause state follows the hold input only while
// the serial clock is low. Assumes synchronised inputs.
module spi_mem_clkev (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_s,
    input  logic hold_s,
    output logic rise_ev,
    output logic fall_ev,
    output logic paused
);
    logic sck_q;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Pause state: cleared by deselect, updated only while the clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      paused <= 1'b0;
        else if (cs_s)   paused <= 1'b0;
        else if (!sck_s) paused <= !hold_s;
    end

    assign rise_ev = !cs_s && !paused &&  sck_s && !sck_q;
    assign fall_ev = !cs_s && !paused && !sck_s &&  sck_q;
endmodule

// File: rtl/spi_mem_seq.sv
// Command sequencer: shifts in bytes on rise events, decodes the command,
// collects the address, streams read or status data on fall events and
// forwards write bytes. Assumes a read-port latency of one clock and serial
// clock phases several system clocks long. ADDR_W must be at least 9.
module spi_mem_seq
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              si_s,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              paused,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        mem_rd_data_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_req_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    output logic              op_wren_o,
    output logic              op_wrdi_o,
    output logic              sr_wr_vld_o,
    output logic              wr_byte_vld_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_byte_o,
    output logic              wr_commit_o
);
    localparam int AB_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

    phase_t            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sh;
    logic [AB_W-1:0]   abyte;
    logic [ADDR_W-1:0] addr_r;
    logic              is_read;
    logic [7:0]        tx_sh;
    logic [7:0]        nxt_byte;
    logic              rd_pend;
    logic              out_on;
    logic              wr_any;

    logic [7:0]        byte_in;
    logic              byte_done;
    logic              out_phase;
    opkind_t           opk;

    assign byte_in   = {rx_sh, si_s};
    assign byte_done = rise_ev && (bit_cnt == 3'd7);
    assign opk       = decode_op(byte_in);
    assign out_phase = (phase == PH_RD) || (phase == PH_STAT);
    assign so_o      = tx_sh[7];
    assign so_oe_o   = out_on && out_phase && !paused && !cs_s;

    // Main sequence: byte assembly, decode, address, data paths and output shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase         <= PH_IDLE;
            bit_cnt       <= '0;
            rx_sh         <= '0;
            abyte         <= '0;
            addr_r        <= '0;
            is_read       <= 1'b0;
            tx_sh         <= '0;
            nxt_byte      <= '0;
            rd_pend       <= 1'b0;
            out_on        <= 1'b0;
            wr_any        <= 1'b0;
            mem_rd_req_o  <= 1'b0;
            mem_rd_addr_o <= '0;
            op_wren_o     <= 1'b0;
            op_wrdi_o     <= 1'b0;
            sr_wr_vld_o   <= 1'b0;
            wr_byte_vld_o <= 1'b0;
            wr_addr_o     <= '0;
            wr_byte_o     <= '0;
            wr_commit_o   <= 1'b0;
        end else begin
            op_wren_o     <= 1'b0;
            op_wrdi_o     <= 1'b0;
            sr_wr_vld_o   <= 1'b0;
            wr_byte_vld_o <= 1'b0;
            wr_commit_o   <= 1'b0;
            mem_rd_req_o  <= 1'b0;
            rd_pend       <= mem_rd_req_o;
            if (rd_pend) nxt_byte <= mem_rd_data_i;

            if (cs_s) begin
                if (phase == PH_WR && wr_any) wr_commit_o <= 1'b1;
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                abyte   <= '0;
                out_on  <= 1'b0;
                wr_any  <= 1'b0;
            end else begin
                if (rise_ev) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sh   <= byte_in[6:0];
                end
                if (byte_done) begin
                    case (phase)
                        PH_IDLE: begin
                            if (busy_i && opk != OPK_RDSR) begin
                                phase <= PH_MUTE;
                            end else begin
                                case (opk)
                                    OPK_WREN:  begin op_wren_o <= 1'b1; phase <= PH_MUTE; end
                                    OPK_WRDI:  begin op_wrdi_o <= 1'b1; phase <= PH_MUTE; end
                                    OPK_RDSR:  phase <= PH_STAT;
                                    OPK_WRSR:  phase <= PH_SRIN;
                                    OPK_READ:  begin phase <= PH_ADDR; is_read <= 1'b1; end
                                    OPK_WRITE: begin phase <= PH_ADDR; is_read <= 1'b0; end
                                    default:   phase <= PH_MUTE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            addr_r <= {addr_r[ADDR_W-9:0], byte_in};
                            abyte  <= abyte + 1'b1;
                            if (abyte == AB_LAST) begin
                                if (is_read) begin
                                    phase         <= PH_RD;
                                    mem_rd_req_o  <= 1'b1;
                                    mem_rd_addr_o <= {addr_r[ADDR_W-9:0], byte_in};
                                end else begin
                                    phase <= PH_WR;
                                end
                            end
                        end
                        PH_WR: begin
                            wr_byte_vld_o        <= 1'b1;
                            wr_byte_o            <= byte_in;
                            wr_addr_o            <= addr_r;
                            addr_r[PAGE_W-1:0]   <= addr_r[PAGE_W-1:0] + 1'b1;
                            wr_any               <= 1'b1;
                        end
                        PH_SRIN: begin
                            sr_wr_vld_o <= 1'b1;
                            wr_byte_o   <= byte_in;
                            phase       <= PH_MUTE;
                        end
                        default: ;
                    endcase
                end
                if (fall_ev && out_phase) begin
                    if (bit_cnt == 3'd0) begin
                        out_on <= 1'b1;
                        if (phase == PH_RD) begin
                            tx_sh         <= nxt_byte;
                            mem_rd_req_o  <= 1'b1;
                            mem_rd_addr_o <= mem_rd_addr_o + ADDR_W'(1);
                        end else begin
                            tx_sh <= status_i;
                        end
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_cmd_if.sv
// Top of the serial memory command interface: synchronises the pins, derives
// serial clock events and runs the command sequencer.
// Assumes the system clock is at least eight times the serial clock.
module spi_mem_cmd_if #(
    parameter int ADDR_W     = 17,
    parameter int ADDR_BYTES = 3,
    parameter int PAGE_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        mem_rd_data_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_req_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    output logic              op_wren_o,
    output logic              op_wrdi_o,
    output logic              sr_wr_vld_o,
    output logic              wr_byte_vld_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_byte_o,
    output logic              wr_commit_o
);
    logic cs_s, hold_s, sck_s, si_s;
    logic rise_ev, fall_ev, paused;

    spi_mem_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, hold_n_i, sck_i, si_i}),
        .q     ({cs_s, hold_s, sck_s, si_s})
    );

    spi_mem_clkev u_clkev (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .cs_s    (cs_s),
        .hold_s  (hold_s),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .paused  (paused)
    );

    spi_mem_seq #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES), .PAGE_W(PAGE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_s          (cs_s),
        .si_s          (si_s),
        .rise_ev       (rise_ev),
        .fall_ev       (fall_ev),
        .paused        (paused),
        .busy_i        (busy_i),
        .status_i      (status_i),
        .mem_rd_data_i (mem_rd_data_i),
        .so_o          (so_o),
        .so_oe_o       (so_oe_o),
        .mem_rd_req_o  (mem_rd_req_o),
        .mem_rd_addr_o (mem_rd_addr_o),
        .op_wren_o     (op_wren_o),
        .op_wrdi_o     (op_wrdi_o),
        .sr_wr_vld_o   (sr_wr_vld_o),
        .wr_byte_vld_o (wr_byte_vld_o),
        .wr_addr_o     (wr_addr_o),
        .wr_byte_o     (wr_byte_o),
        .wr_commit_o   (wr_commit_o)
    );
endmodule

// File: rtl/spi_mem_cmd_if_chk.sv
// Property checker for the command interface, bound into the top module.
// Observes synchronised select, pause state and the block outputs.
module spi_mem_cmd_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic paused,
    input logic busy_i,
    input logic so_o,
    input logic so_oe_o,
    input logic mem_rd_req_o,
    input logic op_wren_o,
    input logic op_wrdi_o,
    input logic sr_wr_vld_o,
    input logic wr_byte_vld_o
);
    p_oe_off_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !so_oe_o);

    p_oe_off_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_oe_o);

    p_so_frozen_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> $stable(so_o));

    p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_wren_o, op_wrdi_o, sr_wr_vld_o, wr_byte_vld_o}));

    p_no_cmd_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wren_o || op_wrdi_o) |-> !$past(busy_i));

    p_req_only_selected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req_o |-> !$past(cs_s));
endmodule

bind spi_mem_cmd_if spi_mem_cmd_if_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_s          (cs_s),
    .paused        (paused),
    .busy_i        (busy_i),
    .so_o          (so_o),
    .so_oe_o       (so_oe_o),
    .mem_rd_req_o  (mem_rd_req_o),
    .op_wren_o     (op_wren_o),
    .op_wrdi_o     (op_wrdi_o),
    .sr_wr_vld_o   (sr_wr_vld_o),
    .wr_byte_vld_o (wr_byte_vld_o)
);

// File: tb/spi_mem_cmd_if_tb_top.sv
// Self-checking bench: drives a serial host in modes 0 and 3, models a
// one-clock-latency array, and compares against values computed here.
module spi_mem_cmd_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0]  status = 8'h8D;
    logic [7:0]  mem_q = 8'h00;
    logic        so_o, so_oe_o, mem_rd_req_o, op_wren_o, op_wrdi_o;
    logic        sr_wr_vld_o, wr_byte_vld_o, wr_commit_o;
    logic [16:0] mem_rd_addr_o, wr_addr_o;
    logic [7:0]  wr_byte_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_cmd_if dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .busy_i(busy), .status_i(status), .mem_rd_data_i(mem_q),
        .so_o(so_o), .so_oe_o(so_oe_o), .mem_rd_req_o(mem_rd_req_o),
        .mem_rd_addr_o(mem_rd_addr_o), .op_wren_o(op_wren_o), .op_wrdi_o(op_wrdi_o),
        .sr_wr_vld_o(sr_wr_vld_o), .wr_byte_vld_o(wr_byte_vld_o), .wr_addr_o(wr_addr_o),
        .wr_byte_o(wr_byte_o), .wr_commit_o(wr_commit_o)
    );

    function automatic logic [7:0] mem_val(input logic [16:0] a);
        return a[7:0] ^ {a[16], a[14:8]} ^ 8'h3C;
    endfunction

    // Array model with one clock of read latency.
    always @(posedge clk) if (mem_rd_req_o) mem_q <= mem_val(mem_rd_addr_o);

    int n_wren = 0, n_wrdi = 0, n_sr = 0, n_commit = 0, n_req = 0, n_wr = 0, n_oe = 0;
    logic [7:0]  sr_last = 8'h00;
    logic [16:0] last_req_addr = '0;
    logic [16:0] wl_a [0:15];
    logic [7:0]  wl_d [0:15];

    // Output event monitor.
    always @(posedge clk) begin
        if (op_wren_o) n_wren++;
        if (op_wrdi_o) n_wrdi++;
        if (sr_wr_vld_o) begin n_sr++; sr_last = wr_byte_o; end
        if (wr_commit_o) n_commit++;
        if (so_oe_o) n_oe++;
        if (mem_rd_req_o) begin n_req++; last_req_addr = mem_rd_addr_o; end
        if (wr_byte_vld_o && n_wr < 16) begin
            wl_a[n_wr] = wr_addr_o; wl_d[n_wr] = wr_byte_o; n_wr++;
        end
    end

    int n_chk = 0, n_bad = 0, mode = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk);
        sck = (mode == 3);
        half_wait();
        cs_n = 1'b0;
        half_wait();
    endtask

    task automatic desel();
        if (mode == 0) sck = 1'b0;
        half_wait();
        cs_n = 1'b1;
        half_wait(); half_wait();
    endtask

    // One byte: drive on the low phase, sample SO just before the rising edge.
    task automatic xbyte(input logic [7:0] tx, input int hold_at,
                         output logic [7:0] rx, output bit oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i];
            half_wait();
            if (7 - i == hold_at) begin
                hold_n = 1'b0;
                repeat (4) @(negedge clk);
                check(!so_oe_o, "R7 enable low while paused", so_oe_o, 0);
                repeat (2) begin
                    sck = 1'b1; si = ~si; half_wait();
                    sck = 1'b0; half_wait();
                end
                si = tx[i]; hold_n = 1'b1;
                half_wait();
            end
            rx[i] = so_o;
            if (!so_oe_o) oe_all = 1'b0;
            sck = 1'b1;
            half_wait();
        end
    endtask

    task automatic do_read(input logic [7:0] opc, input logic [23:0] a, input int n,
                           input int hold_byte, input string tag);
        logic [7:0]  rx;
        bit          oe;
        logic [16:0] ea;
        int          req0;
        sel();
        req0 = n_req;
        xbyte(opc, -1, rx, oe);
        xbyte(a[23:16], -1, rx, oe);
        xbyte(a[15:8], -1, rx, oe);
        xbyte(a[7:0], -1, rx, oe);
        check(n_req - req0 == 1 && last_req_addr == a[16:0],
              "R11 request issued before first data bit", int'(last_req_addr), int'(a[16:0]));
        ea = a[16:0];
        for (int k = 0; k < n; k++) begin
            xbyte(8'($urandom), (k == hold_byte) ? 3 : -1, rx, oe);
            check(rx == mem_val(ea) && oe, tag, int'(rx), int'(mem_val(ea)));
            ea = ea + 17'd1;
        end
        desel();
    endtask

    initial begin
        logic [7:0] rx;
        bit oe;
        int c0, c1;
        logic [7:0] d [0:3];
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!so_oe_o && !mem_rd_req_o && !op_wren_o, "R6 reset state", so_oe_o, 0);

        // R2: set/clear write enable with bit 3 clear and set, mode 0 and 3.
        mode = 0; c0 = n_wren;
        sel(); xbyte(8'h06, -1, rx, oe); desel();
        mode = 3;
        sel(); xbyte(8'h0E, -1, rx, oe); desel();
        check(n_wren - c0 == 2, "R2 write-enable pulses", n_wren - c0, 2);
        c0 = n_wrdi;
        sel(); xbyte(8'h0C, -1, rx, oe); desel();
        mode = 0;
        sel(); xbyte(8'h04, -1, rx, oe); desel();
        check(n_wrdi - c0 == 2, "R2 write-disable pulses", n_wrdi - c0, 2);

        // R3: illegal commands mute the rest of the selection.
        c0 = n_oe; c1 = n_wren;
        sel(); xbyte(8'h07, -1, rx, oe); xbyte(8'h06, -1, rx, oe);
        xbyte(8'h03, -1, rx, oe); desel();
        sel(); xbyte(8'h16, -1, rx, oe); xbyte(8'h06, -1, rx, oe); desel();
        check(n_oe == c0 && n_wren == c1, "R3 illegal command ignored", n_wren - c1, 0);
        sel(); xbyte(8'h06, -1, rx, oe); desel();
        check(n_wren == c1 + 1, "R3 fresh selection decodes again", n_wren - c1, 1);

        // R6: clocking while deselected does nothing.
        c0 = n_wren; c1 = n_oe;
        for (int i = 0; i < 16; i++) begin
            sck = 1'b0; si = (i % 8 == 5 || i % 8 == 6); half_wait();
            sck = 1'b1; half_wait();
        end
        sck = 1'b0; half_wait();
        check(n_wren == c0 && n_oe == c1, "R6 input ignored while deselected", n_wren - c0, 0);

        // R1 R4 R5: directed reads in both modes, bit 3 variant, full wrap.
        mode = 0; do_read(8'h03, 24'hA5_2C41, 3, -1, "R1 R4 mode 0 read");
        mode = 3; do_read(8'h0B, 24'h7F_0123, 3, -1, "R1 R2 mode 3 read");
        mode = 3; do_read(8'h03, 24'hFF_FFFE, 4, -1, "R5 read wraps at top");
        mode = 0; do_read(8'h03, 24'h00_1FFF, 3, 1,  "R7 read resumes after pause");

        // R9: page write with in-page wrap and commit at deselect.
        mode = 0; c0 = n_commit; n_wr = 0;
        for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
        sel(); xbyte(8'h0A, -1, rx, oe);
        xbyte(8'hFE, -1, rx, oe); xbyte(8'hA3, -1, rx, oe); xbyte(8'h7E, -1, rx, oe);
        for (int i = 0; i < 4; i++) xbyte(d[i], -1, rx, oe);
        desel();
        check(n_wr == 4, "R9 write byte count", n_wr, 4);
        for (int i = 0; i < 4; i++) begin
            logic [16:0] ea;
            ea = {10'h0A3 >> 1, 7'((7'h7E + i) % 128)};
            ea = 17'h0A300 | 17'((8'h7E + i) % 128) | 17'h00000;
            check(wl_a[i] == ea && wl_d[i] == d[i], "R9 write address/data",
                  int'(wl_a[i]), int'(ea));
        end
        check(n_commit == c0 + 1, "R9 commit at deselect", n_commit - c0, 1);

        // R10: status write forwards one byte.
        c0 = n_sr;
        sel(); xbyte(8'h01, -1, rx, oe); xbyte(8'h8C, -1, rx, oe); xbyte(8'h11, -1, rx, oe); desel();
        check(n_sr == c0 + 1 && sr_last == 8'h8C, "R10 status write byte", int'(sr_last), 8'h8C);

        // R8: busy blocks all but status read; R10 status streams repeatedly.
        busy = 1'b1; c0 = n_wren; c1 = n_oe;
        sel(); xbyte(8'h06, -1, rx, oe); desel();
        check(n_wren == c0, "R8 write enable ignored while busy", n_wren - c0, 0);
        c0 = n_req;
        sel(); xbyte(8'h03, -1, rx, oe); xbyte(8'h00, -1, rx, oe);
        xbyte(8'h00, -1, rx, oe); xbyte(8'h10, -1, rx, oe); xbyte(8'h00, -1, rx, oe); desel();
        check(n_req == c0 && n_oe == c1, "R8 read ignored while busy", n_req - c0, 0);
        mode = 3;
        sel(); xbyte(8'h05, -1, rx, oe);
        xbyte(8'h00, -1, rx, oe);
        check(rx == status && oe, "R8 R10 status first byte", int'(rx), int'(status));
        status = 8'h3B;
        xbyte(8'hFF, -1, rx, oe);
        check(rx == 8'h3B && oe, "R10 status repeated", int'(rx), 8'h3B);
        desel();
        busy = 1'b0;

        // R5: random reads, random mode and address.
        for (int t = 0; t < 20; t++) begin
            mode = ($urandom % 2) ? 3 : 0;
            do_read(($urandom % 2) ? 8'h0B : 8'h03, 24'($urandom), 1 + ($urandom % 3),
                    -1, "R5 random read");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule